// File: doc/BRIEF.md
# I2C Bus Timing Supervisor Timer

This block sits beside an I2C controller and keeps time for it. A single 10-bit counter, advanced by a machine-cycle enable pulse, does two jobs. Its three low bits measure how long SCL has been in its current phase, and a one-cycle strobe tells the controller when the minimum high or low time has passed. The whole counter measures how long the bus has gone without activity inside a frame, and it raises a sticky timeout flag and an interrupt request when the bus looks hung.

The block watches the synchronized SCL and SDA lines itself. Any change on SCL, a Start (SDA falling while SCL stays high) or a Stop (SDA rising while SCL stays high) restarts the timing. A frame opens on a Start and closes on a Stop. Three enable bits (slave enable, master request, master active) and a run bit choose one of three operating behaviours. With no enable bit set, the timer is held cleared. With an enable bit set and run low, only the minimum-time field counts. With an enable bit set and run high, the full supervisor is active. A two-bit select field sets both the minimum time and the timeout period.

Top module: `scl_guard_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, min_done, to_flag and to_irq are all 0.
- R2: When slv_en, mst_req and mst_act are all 0, the counter and the frame state are held cleared whatever run_en is, so no min_done pulse and no timeout can occur.
- R3: Any one of slv_en, mst_req or mst_act set alone enables the supervisor.
- R4: With an enable bit set and run_en = 0, only the low 3 bits count; they stop at 7, the upper 7 bits hold their value, and no timeout is ever raised.
- R5: cnt_sel gives the minimum time N in ticks: 2'b10 gives 7, 2'b01 gives 6, 2'b00 gives 5 and 2'b11 gives 4. min_done is high for exactly one cycle, in the cycle after the clock edge that takes the N-th tick since the last restart.
- R6: With an enable bit set and run_en = 1, the counter advances only inside a frame and is held at 0 outside one. to_flag sets on the edge that takes the T-th tick since the last restart, where T is 1023, 1022, 1021 or 1020 for cnt_sel 2'b10, 2'b01, 2'b00 or 2'b11. The count then stops at T.
- R7: An SCL change, a Start or a Stop clears the whole counter in full mode and the low 3 bits in minimum-only mode. If an event and a tick fall in the same cycle, the event wins.
- R8: The counter advances only in cycles where mc_tick is 1.
- R9: to_flag stays set until to_clr is pulsed, and to_irq follows it. If a timeout and to_clr arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_en | input | 1 | Slave function enable |
| mst_req | input | 1 | Master request |
| mst_act | input | 1 | Master active status |
| run_en | input | 1 | Enables hung-bus supervision |
| cnt_sel | input | 2 | Minimum-time and timeout select |
| mc_tick | input | 1 | Machine-cycle enable pulse |
| scl_s | input | 1 | Synchronized SCL |
| sda_s | input | 1 | Synchronized SDA |
| to_clr | input | 1 | Clears the timeout flag |
| min_done | output | 1 | One-cycle minimum-time strobe |
| to_flag | output | 1 | Sticky hung-bus flag |
| to_irq | output | 1 | Interrupt request from the timeout |

## Verification
Two pairs of functions can meet in one cycle. A new timeout can arrive together with a software clear of the flag, and a bus event can arrive together with a count tick. The first case is provoked by pulsing to_clr on exactly the T-th tick after an SCL change, and it is judged correct only if to_flag reads 1 afterwards. The second case is covered by the table rows and the Start steps, where mc_tick stays high while SCL or SDA moves: the count must restart at zero, and the minimum-time strobe must then appear exactly N ticks later.

// File: rtl/scl_guard_pkg.sv
package scl_guard_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_MIN  = 2'd1,
    MODE_FULL = 2'd2
  } sg_mode_e;

  // select rank: 11 -> 0, 00 -> 1, 01 -> 2, 10 -> 3
  function automatic logic [1:0] sel_rank(input logic [1:0] sel);
    return (sel == 2'b11) ? 2'd0 : sel + 2'd1;
  endfunction
endpackage

// File: rtl/sg_bus_events.sv
module sg_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_chg,
  output logic start_p,
  output logic stop_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_chg = scl_s ^ scl_q;
  assign start_p = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sg_mode_decode.sv
module sg_mode_decode
  import scl_guard_pkg::*;
(
  input  logic     slv_en,
  input  logic     mst_req,
  input  logic     mst_act,
  input  logic     run_en,
  output sg_mode_e mode
);
  logic any_en;
  assign any_en = slv_en | mst_req | mst_act;

  always_comb begin
    if (!any_en)     mode = MODE_OFF;
    else if (run_en) mode = MODE_FULL;
    else             mode = MODE_MIN;
  end
endmodule

// File: rtl/sg_phase_counter.sv
module sg_phase_counter
  import scl_guard_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LOW_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  sg_mode_e   mode,
  input  logic [1:0] cnt_sel,
  input  logic       tick,
  input  logic       scl_chg,
  input  logic       start_p,
  input  logic       stop_p,
  output logic       min_done,
  output logic       tmo_hit
);
  localparam int MIN_BASE = (1 << LOW_W) - 4;
  localparam int TO_BASE  = (1 << CNT_W) - 4;
  localparam logic [LOW_W-1:0] LOW_MAX = '1;

  logic [CNT_W-1:0] cnt, min_full, tmo_full;
  logic [LOW_W-1:0] low, low_inc, min_low;
  logic             frame, evt, min_hit;

  assign evt      = scl_chg | start_p | stop_p;
  assign min_full = CNT_W'(MIN_BASE) + CNT_W'(sel_rank(cnt_sel));
  assign tmo_full = CNT_W'(TO_BASE) + CNT_W'(sel_rank(cnt_sel));
  assign min_low  = min_full[LOW_W-1:0];
  assign low      = cnt[LOW_W-1:0];
  assign low_inc  = low + 1'b1;

  always_comb begin
    min_hit = 1'b0;
    tmo_hit = 1'b0;
    if (tick && !evt) begin
      if (mode == MODE_MIN)
        min_hit = (low != LOW_MAX) && (low_inc == min_low);
      else if (mode == MODE_FULL && frame) begin
        min_hit = (cnt == min_full - 1'b1);
        tmo_hit = (cnt == tmo_full - 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      frame    <= 1'b0;
      min_done <= 1'b0;
    end else begin
      min_done <= min_hit;
      if (mode == MODE_OFF) begin
        cnt   <= '0;
        frame <= 1'b0;
      end else begin
        if (start_p)     frame <= 1'b1;
        else if (stop_p) frame <= 1'b0;
        if (mode == MODE_MIN) begin
          if (evt)                         cnt[LOW_W-1:0] <= '0;
          else if (tick && low != LOW_MAX) cnt[LOW_W-1:0] <= low_inc;
        end else begin
          if (evt || !frame)                cnt <= '0;
          else if (tick && cnt != tmo_full) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_off_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> (cnt == '0 && !min_done));
  assert_upper_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MIN) |=> $stable(cnt[CNT_W-1:LOW_W]));
  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    min_done |=> !min_done);
  assert_evt_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FULL && evt) |=> (cnt == '0));
  assert_tick_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !evt && (mode == MODE_MIN || (mode == MODE_FULL && frame)))
      |=> $stable(cnt));
endmodule

// File: rtl/sg_timeout_flag.sv
module sg_timeout_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_p,
  input  logic clr_p,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (set_p) flag <= 1'b1;
    else if (clr_p) flag <= 1'b0;
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_p) |=> flag);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_p |=> flag);
endmodule

// File: rtl/scl_guard_timer.sv
module scl_guard_timer
  import scl_guard_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LOW_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slv_en,
  input  logic       mst_req,
  input  logic       mst_act,
  input  logic       run_en,
  input  logic [1:0] cnt_sel,
  input  logic       mc_tick,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       to_clr,
  output logic       min_done,
  output logic       to_flag,
  output logic       to_irq
);
  sg_mode_e mode;
  logic     scl_chg, start_p, stop_p, tmo_hit;

  sg_bus_events u_evt (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_chg(scl_chg), .start_p(start_p), .stop_p(stop_p)
  );

  sg_mode_decode u_mode (
    .slv_en(slv_en), .mst_req(mst_req), .mst_act(mst_act),
    .run_en(run_en), .mode(mode)
  );

  sg_phase_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk(clk), .rst(rst), .mode(mode), .cnt_sel(cnt_sel), .tick(mc_tick),
    .scl_chg(scl_chg), .start_p(start_p), .stop_p(stop_p),
    .min_done(min_done), .tmo_hit(tmo_hit)
  );

  sg_timeout_flag u_flag (
    .clk(clk), .rst(rst), .set_p(tmo_hit), .clr_p(to_clr), .flag(to_flag)
  );

  assign to_irq = to_flag;

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    to_irq == to_flag);
endmodule

// File: tb/sim_scl_guard_timer.sv
module sim_scl_guard_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slv_en = 0, mst_req = 0, mst_act = 0, run_en = 0, mc_tick = 0;
  logic [1:0] cnt_sel = 2'b00;
  logic scl_s = 1, sda_s = 1, to_clr = 0;
  logic min_done, to_flag, to_irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scl_guard_timer u0 (
    .clk(clk), .rst(rst), .slv_en(slv_en), .mst_req(mst_req), .mst_act(mst_act),
    .run_en(run_en), .cnt_sel(cnt_sel), .mc_tick(mc_tick), .scl_s(scl_s),
    .sda_s(sda_s), .to_clr(to_clr), .min_done(min_done), .to_flag(to_flag),
    .to_irq(to_irq)
  );

  // row: {slv_en, run_en, cnt_sel[1:0], mc_tick, scl_s, sda_s, expected min_done}
  localparam logic [7:0] VEC [18] = '{
    8'b1_0_11_1_1_1_0, 8'b1_0_11_1_1_1_0, 8'b1_0_11_1_1_1_0, 8'b1_0_11_1_1_1_1,
    8'b1_0_11_1_1_1_0, 8'b1_0_11_1_0_1_0, 8'b1_0_11_0_0_1_0, 8'b1_0_00_1_0_1_0,
    8'b1_0_00_1_0_1_0, 8'b1_0_00_1_0_1_0, 8'b1_0_00_1_0_1_0, 8'b1_0_00_1_0_1_1,
    8'b0_0_00_1_0_1_0, 8'b0_1_00_1_0_1_0, 8'b1_0_11_1_0_1_0, 8'b1_0_11_1_0_1_0,
    8'b1_0_11_1_0_1_0, 8'b1_0_11_1_0_1_1
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic watch_quiet(input string tag, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (min_done || to_flag) hits++;
    end
    checks++;
    if (hits != 0) begin
      errors++;
      $display("FAIL %s actual=%0d expected=0", tag, hits);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    steps(3);
    chk("R1 flag in reset", to_flag, 1'b0);
    chk("R1 min in reset", min_done, 1'b0);
    rst = 0;
    step();
    chk("R1 flag after reset", to_flag, 1'b0);
    chk("R1 irq after reset", to_irq, 1'b0);

    // table: R5 select encoding, R7 SCL restart, R8 tick gating, R2 off modes
    for (int i = 0; i < 18; i++) begin
      {slv_en, run_en, cnt_sel, mc_tick, scl_s, sda_s} = VEC[i][7:1];
      step();
      chk($sformatf("R2/R5/R7/R8 table row %0d", i), min_done, VEC[i][0]);
    end

    // full mode from a Start, select 11: N=4, T=1020 (R5, R6, R7)
    scl_s = 1; step();
    run_en = 1; sda_s = 0; step();
    steps(3);
    chk("R5 full mode before N", min_done, 1'b0);
    step();
    chk("R5 full mode strobe at N=4", min_done, 1'b1);
    steps(1015);
    chk("R6 no timeout at T-1", to_flag, 1'b0);
    step();
    chk("R6 timeout at T=1020", to_flag, 1'b1);
    chk("R9 irq follows flag", to_irq, 1'b1);
    steps(5);
    chk("R9 flag sticky", to_flag, 1'b1);
    to_clr = 1; step(); to_clr = 0;
    chk("R9 clear drops flag", to_flag, 1'b0);
    steps(20);
    chk("R6 count stops at T", to_flag, 1'b0);

    // mst_act alone, select 10: T=1023; clear coincides with timeout (R3, R6, R9)
    slv_en = 0; mst_act = 1; cnt_sel = 2'b10; scl_s = 0; step();
    steps(1022);
    chk("R6 no timeout at 1022 for select 10", to_flag, 1'b0);
    to_clr = 1; step(); to_clr = 0;
    chk("R9 timeout wins over clear", to_flag, 1'b1);

    // minimum-only mode, select 10: N=7, never a timeout (R4, R5)
    to_clr = 1; step(); to_clr = 0;
    chk("R9 clear before min-only test", to_flag, 1'b0);
    mst_act = 0; slv_en = 1; run_en = 0; scl_s = 1; step();
    steps(6);
    chk("R4 min-only before N=7", min_done, 1'b0);
    step();
    chk("R4 min-only strobe at N=7", min_done, 1'b1);
    step();
    chk("R5 strobe one cycle", min_done, 1'b0);
    watch_quiet("R4 no timeout or restrobe in min-only", 1100);

    // mst_req alone; outside a frame nothing counts (R3, R6)
    slv_en = 0; mst_req = 1; run_en = 1; cnt_sel = 2'b11; sda_s = 1; step();
    watch_quiet("R6 held outside frame after Stop", 1100);
    sda_s = 0; step();
    steps(1019);
    chk("R3 mst_req no timeout at T-1", to_flag, 1'b0);
    step();
    chk("R3 mst_req timeout at T", to_flag, 1'b1);

    // all enables low with run high: held cleared (R2)
    to_clr = 1; step(); to_clr = 0;
    mst_req = 0; sda_s = 1; step();
    sda_s = 0; step();
    watch_quiet("R2 disabled with run high", 1100);

    // tick low inside a frame: no progress (R8)
    mst_req = 1; mc_tick = 0; sda_s = 1; step();
    sda_s = 0; step();
    steps(2000);
    chk("R8 no timeout without ticks", to_flag, 1'b0);
    mc_tick = 1;
    steps(1019);
    chk("R8 no timeout at T-1 ticks", to_flag, 1'b0);
    step();
    chk("R8 timeout after T ticks", to_flag, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule